// File: doc/BRIEF.md
# Synchronous Serial Port with Selectable Frame Format

This block lets an on-chip processor exchange words with an outside device over a bit-serial link. The outside device supplies the only serial clock. One clock edge drives the output line and the opposite edge samples the input line. The processor reaches the port through four word-wide registers in its data address space: received data, data to send, status, and control.

The frame length can be 8 or 16 bits, and the order can be most-significant bit first or least-significant bit first. Each choice is set separately for receive and for transmit. Each direction has its own status line toward the outside device: one says a receive frame can be accepted, the other says a transmit frame is waiting to be clocked out.

Inside the chip, software learns that a frame is done in one of three ways. It can poll the status register. It can turn on bus stalling, so that an access which cannot finish yet holds the bus until it can. Or it can enable an interrupt per direction. Frame completion crosses from the serial clock into the system clock through toggle flags and synchronisers.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status register (address 2) reads 0x0002, the control register (address 3) reads 0, `si_rdy` is high, `so_req` is low, `irq` is low and `bus_ready` is high.
- R2: With `si_valid` high, `sdi` is sampled on each rising `sclk` edge. Control bit 1 selects the receive order: 0 means the first bit is the most significant, 1 means the first bit is bit 0. A completed frame is read at address 0.
- R3: Control bit 0 selects the receive length: 0 means 8 bits, 1 means 16 bits. An 8-bit frame appears in bits 7:0 of the read value, and bits 15:8 read as zero.
- R4: A word written at address 1 is presented on `sdo` one bit at a time, and each falling `sclk` edge moves to the next bit. Control bit 2 selects the length: 0 sends bits 7:0, 1 sends all 16 bits. Control bit 3 selects the order: 0 means most significant first, 1 means bit 0 first.
- R5: `si_rdy` falls right after the rising edge that completes a receive frame, and rises again when software reads the data. `so_req` is high from the transmit write until the falling edge that ends the frame.
- R6: Status bit 0 (receive full) is set once a received frame reaches the system side and is cleared by reading address 0. Status bit 1 (transmit empty) is cleared by writing address 1 and set again once the frame has been sent.
- R7: With control bit 4 at 0, reading address 0 while receive full is clear changes no state. Writing address 1 while a frame is still pending is ignored and keeps the earlier word.
- R8: With control bit 4 at 1, `bus_ready` is held low on a read of address 0 until a frame has arrived, and on a write of address 1 until the previous frame has been sent. The access then completes normally.
- R9: `irq` is high whenever receive full is set with control bit 5 at 1, or transmit empty is set with control bit 6 at 1. Status bit 2 mirrors `irq`.
- R10: Control bits 6:0 are read back at address 3, and bits 15:7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 rx data, 1 tx data, 2 status, 3 control) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while selected |
| bus_ready | output | 1 | Low while an access is stalled |
| irq | output | 1 | Level interrupt request |
| sclk | input | 1 | External serial clock |
| si_valid | input | 1 | High while the outside device presents a receive frame |
| sdi | input | 1 | Serial data in |
| si_rdy | output | 1 | Port can accept a receive frame |
| sdo | output | 1 | Serial data out |
| so_req | output | 1 | A transmit frame is waiting or in progress |

## Verification
A wrong bit index or order setting corrupts the very first frame in that configuration. It shows as a miscompare on `sdo` during the frame, or in the word read back three system cycles after the frame ends. A lost or doubled handshake toggle leaves `si_rdy` or `so_req` stuck. That stalls the next frame at once and hangs any waiting bus access, so a wrong flag shows within one frame time. The sweep covers every length and order combination in both directions with varied data words, so a fault in any one configuration is reached.

// File: rtl/sync_serial_port.sv
module sync_serial_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_ready,
  output logic        irq,
  input  logic        sclk,
  input  logic        si_valid,
  input  logic        sdi,
  output logic        si_rdy,
  output logic        sdo,
  output logic        so_req
);
  localparam logic [1:0] A_RX = 2'd0, A_TX = 2'd1, A_ST = 2'd2, A_CT = 2'd3;

  logic [6:0] ctl;
  wire rx16 = ctl[0], rx_lsb = ctl[1], tx16 = ctl[2], tx_lsb = ctl[3];
  wire wait_en = ctl[4], rx_ie = ctl[5], tx_ie = ctl[6];

  // receive path, sclk domain
  logic [15:0] rx_sh, rx_nxt;
  logic [3:0]  rx_cnt;
  logic        rx_done_t, rx_take;
  wire         rx_open = (rx_done_t == rx_take);
  wire [3:0]   rx_last = rx16 ? 4'd15 : 4'd7;

  always_comb begin
    rx_nxt = (rx_cnt == 4'd0) ? 16'h0000 : rx_sh;
    if (rx_lsb) rx_nxt[rx_cnt] = sdi;
    else        rx_nxt = {rx_nxt[14:0], sdi};
  end

  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n) begin
      rx_sh <= '0; rx_cnt <= '0; rx_done_t <= 1'b0;
    end else if (rx_open && si_valid) begin
      rx_sh <= rx_nxt;
      if (rx_cnt == rx_last) begin
        rx_cnt    <= '0;
        rx_done_t <= ~rx_done_t;
      end else rx_cnt <= rx_cnt + 4'd1;
    end

  // transmit path, sclk domain
  logic [15:0] tx_buf;
  logic [3:0]  tx_cnt;
  logic        tx_req, tx_ack;
  wire         tx_busy = tx_req ^ tx_ack;
  wire [3:0]   tx_last = tx16 ? 4'd15 : 4'd7;
  wire [3:0]   tx_pos  = tx_lsb ? tx_cnt : tx_last - tx_cnt;

  always_ff @(negedge sclk or negedge rst_n)
    if (!rst_n) begin
      tx_cnt <= '0; tx_ack <= 1'b0;
    end else if (tx_busy) begin
      if (tx_cnt == tx_last) begin
        tx_cnt <= '0;
        tx_ack <= ~tx_ack;
      end else tx_cnt <= tx_cnt + 4'd1;
    end

  assign sdo    = tx_busy & tx_buf[tx_pos];
  assign so_req = tx_busy;
  assign si_rdy = rx_open;

  // completion flags into clk domain
  logic [2:0]  rx_s;
  logic [1:0]  tx_s;
  logic [15:0] rx_data;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s <= '0; tx_s <= '0;
    end else begin
      rx_s <= {rx_s[1:0], rx_done_t};
      tx_s <= {tx_s[0], tx_ack};
    end

  wire rx_evt   = rx_s[1] ^ rx_s[2];
  wire rx_full  = rx_s[2] ^ rx_take;
  wire tx_empty = (tx_s[1] == tx_req);
  assign irq = (rx_ie & rx_full) | (tx_ie & tx_empty);

  // bus side
  wire rd = bus_sel & ~bus_wr;
  wire wr = bus_sel & bus_wr;
  assign bus_ready = ~(wait_en & ((rd & (bus_addr == A_RX) & ~rx_full) |
                                  (wr & (bus_addr == A_TX) & ~tx_empty)));
  wire go = bus_sel & bus_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl <= '0; tx_buf <= '0; tx_req <= 1'b0; rx_take <= 1'b0; rx_data <= '0;
    end else begin
      if (go && bus_wr && bus_addr == A_CT) ctl <= bus_wdata[6:0];
      if (go && bus_wr && bus_addr == A_TX && tx_empty) begin
        tx_buf <= bus_wdata;
        tx_req <= ~tx_req;
      end
      if (go && !bus_wr && bus_addr == A_RX && rx_full) rx_take <= ~rx_take;
      if (rx_evt) rx_data <= rx_sh;
    end

  always_comb
    case (bus_addr)
      A_RX:    bus_rdata = rx_data;
      A_TX:    bus_rdata = tx_buf;
      A_ST:    bus_rdata = {13'b0, irq, tx_empty, rx_full};
      default: bus_rdata = {9'b0, ctl};
    endcase
endmodule

// File: rtl/sync_serial_port_chk.sv
module sync_serial_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic        bus_ready,
  input logic        irq,
  input logic [6:0]  ctl,
  input logic        rx_full,
  input logic        tx_empty,
  input logic [15:0] rx_data
);
  p_rx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && $past(rx_full)) |-> $stable(rx_data));

  p_rx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 2'd0 && bus_ready && rx_full) |=> !rx_full);

  p_tx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd1 && bus_ready && tx_empty) |=> !tx_empty);

  p_nowait_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[4] |-> bus_ready);

  p_wait_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[4] && bus_sel && !bus_wr && bus_addr == 2'd0 && bus_ready) |-> rx_full);

  p_wait_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[4] && bus_sel && bus_wr && bus_addr == 2'd1 && bus_ready) |-> tx_empty);

  p_irq_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[5] && rx_full) |-> irq);

  p_irq_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[6] && tx_empty) |-> irq);
endmodule

bind sync_serial_port sync_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_ready(bus_ready), .irq(irq), .ctl(ctl),
  .rx_full(rx_full), .tx_empty(tx_empty), .rx_data(rx_data)
);

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  localparam time CLK_P = 10;
  localparam time SCK_H = 35;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic bus_ready, irq, sdo, si_rdy, so_req;
  logic sclk = 1'b0, si_valid = 1'b0, sdi = 1'b0;

  int vectors = 0, fails = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_serial_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq(irq), .sclk(sclk), .si_valid(si_valid),
    .sdi(sdi), .si_rdy(si_rdy), .sdo(sdo), .so_req(so_req)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d, output logic stalled);
    int n = 0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    stalled = !bus_ready;
    while (!bus_ready && n < 20000) begin @(negedge clk); #1; n++; end
    d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] v, output logic stalled);
    int n = 0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    #1;
    stalled = !bus_ready;
    while (!bus_ready && n < 20000) begin @(negedge clk); #1; n++; end
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic send_rx(input logic [15:0] v, input logic l16, input logic lsb);
    int n = l16 ? 16 : 8;
    int t = 0;
    while (!si_rdy && t < 50000) begin #CLK_P; t++; end
    si_valid = 1'b1;
    for (int i = 0; i < n; i++) begin
      sdi = lsb ? v[i] : v[n-1-i];
      #SCK_H; sclk = 1'b1; #1;
      if (i == n-1) chk(si_rdy == 1'b0, "R5 si_rdy after last rx bit", {15'b0, si_rdy}, 16'h0);
      #(SCK_H-1); sclk = 1'b0;
    end
    si_valid = 1'b0; sdi = 1'b0;
  endtask

  task automatic take_tx(input logic l16, input logic lsb, output logic [15:0] got);
    int n = l16 ? 16 : 8;
    int t = 0;
    while (!so_req && t < 50000) begin #CLK_P; t++; end
    got = '0;
    for (int i = 0; i < n; i++) begin
      #SCK_H;
      if (lsb) got[i] = sdo;
      else     got = {got[14:0], sdo};
      sclk = 1'b1; #SCK_H; sclk = 1'b0;
    end
    #1;
    chk(so_req == 1'b0, "R5 so_req after last tx bit", {15'b0, so_req}, 16'h0);
  endtask

  initial begin
    logic [15:0] d, got, v, mask;
    logic st;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1;
    chk(si_rdy && !so_req && !irq && bus_ready, "R1 handshake lines",
        {12'b0, si_rdy, so_req, irq, bus_ready}, 16'h0009);
    rd_reg(2'd2, d, st); chk(d == 16'h0002, "R1 status", d, 16'h0002);
    rd_reg(2'd3, d, st); chk(d == 16'h0000, "R1 control", d, 16'h0000);

    // R10 control readback
    wr_reg(2'd3, 16'hFFFF, st);
    rd_reg(2'd3, d, st); chk(d == 16'h007F, "R10 control readback", d, 16'h007F);
    wr_reg(2'd3, 16'h0000, st);

    // R2 R3 R4 R5 R6 sweep of all formats
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic l16 = cfg[1];
      logic lsb = cfg[0];
      mask = l16 ? 16'hFFFF : 16'h00FF;
      wr_reg(2'd3, {12'b0, lsb, l16, lsb, l16}, st);
      for (int k = 0; k < 6; k++) begin
        v = 16'(32'hA5C3 ^ (32'h3B1D * k));
        if (k == 5) v = 16'hFFFF;
        send_rx(v, l16, lsb);
        repeat (5) @(posedge clk);
        rd_reg(2'd2, d, st); chk(d[0] == 1'b1, "R6 rx full set", d, 16'h0001);
        rd_reg(2'd0, d, st);
        chk(d == (v & mask), l16 ? "R2 rx word" : "R3 rx byte zero-filled", d, v & mask);
        rd_reg(2'd2, d, st); chk(d[0] == 1'b0, "R6 rx full cleared", d, 16'h0000);
        chk(si_rdy == 1'b1, "R5 si_rdy after read", {15'b0, si_rdy}, 16'h0001);

        v = ~v ^ 16'(k * 16'h0111);
        wr_reg(2'd1, v, st);
        rd_reg(2'd2, d, st); chk(d[1] == 1'b0, "R6 tx empty cleared", d, 16'h0000);
        chk(so_req == 1'b1, "R5 so_req after write", {15'b0, so_req}, 16'h0001);
        take_tx(l16, lsb, got);
        chk(got == (v & mask), "R4 tx frame", got, v & mask);
        repeat (4) @(posedge clk);
        rd_reg(2'd2, d, st); chk(d[1] == 1'b1, "R6 tx empty set", d, 16'h0002);
      end
    end

    // R7 poll mode ignores
    wr_reg(2'd3, 16'h0000, st);
    rd_reg(2'd0, d, st);
    chk(si_rdy == 1'b1, "R7 empty rx read keeps si_rdy", {15'b0, si_rdy}, 16'h0001);
    rd_reg(2'd2, d, st); chk(d[0] == 1'b0, "R7 empty rx read keeps full clear", d, 16'h0000);
    send_rx(16'h003C, 1'b0, 1'b0);
    repeat (5) @(posedge clk);
    rd_reg(2'd0, d, st); chk(d == 16'h003C, "R7 rx after empty read", d, 16'h003C);
    wr_reg(2'd1, 16'h0011, st);
    wr_reg(2'd1, 16'h0022, st);
    rd_reg(2'd1, d, st); chk(d == 16'h0011, "R7 pending write ignored", d, 16'h0011);
    take_tx(1'b0, 1'b0, got); chk(got == 16'h0011, "R7 tx keeps first word", got, 16'h0011);
    repeat (4) @(posedge clk);

    // R8 wait mode stalls
    wr_reg(2'd3, 16'h0010, st);
    fork
      rd_reg(2'd0, d, st);
      begin #(CLK_P*20); send_rx(16'h005A, 1'b0, 1'b0); end
    join
    chk(st == 1'b1, "R8 rx read stalled", {15'b0, st}, 16'h0001);
    chk(d == 16'h005A, "R8 stalled rx read data", d, 16'h005A);
    wr_reg(2'd1, 16'h00C6, st);
    chk(st == 1'b0, "R8 tx write no stall when empty", {15'b0, st}, 16'h0000);
    fork
      wr_reg(2'd1, 16'h0039, st);
      begin #(CLK_P*10); take_tx(1'b0, 1'b0, got); end
    join
    chk(st == 1'b1, "R8 tx write stalled", {15'b0, st}, 16'h0001);
    chk(got == 16'h00C6, "R8 first tx frame", got, 16'h00C6);
    take_tx(1'b0, 1'b0, got);
    chk(got == 16'h0039, "R8 stalled write delivered", got, 16'h0039);
    repeat (4) @(posedge clk);

    // R9 interrupts
    wr_reg(2'd3, 16'h0020, st);
    #1; chk(irq == 1'b0, "R9 rx irq idle", {15'b0, irq}, 16'h0000);
    send_rx(16'h0077, 1'b0, 1'b0);
    repeat (5) @(posedge clk); #1;
    chk(irq == 1'b1, "R9 rx irq raised", {15'b0, irq}, 16'h0001);
    rd_reg(2'd2, d, st); chk(d == 16'h0007, "R9 status irq bit", d, 16'h0007);
    rd_reg(2'd0, d, st); #1;
    chk(irq == 1'b0, "R9 rx irq cleared by read", {15'b0, irq}, 16'h0000);
    wr_reg(2'd3, 16'h0040, st); #1;
    chk(irq == 1'b1, "R9 tx irq when empty", {15'b0, irq}, 16'h0001);
    wr_reg(2'd1, 16'h0055, st); #1;
    chk(irq == 1'b0, "R9 tx irq cleared by write", {15'b0, irq}, 16'h0000);
    take_tx(1'b0, 1'b0, got);
    repeat (4) @(posedge clk); #1;
    chk(irq == 1'b1, "R9 tx irq after frame", {15'b0, irq}, 16'h0001);

    summary();
    $finish;
  end
endmodule